// File: doc/BRIEF.md
# Private Prescaled Countdown Timer

A per-core countdown timer controlled through four 32-bit memory-mapped registers: reload value, live counter, control and event status. Once enabled, the counter steps down once every (prescaler+1) clock cycles. When it expires it sets a sticky event flag. In one-shot mode it then stops at zero. In auto-reload mode it takes the reload value again and keeps counting. The interrupt output is the event flag qualified by an interrupt-enable bit.

Software reaches the block through a single-cycle register port made of valid, write, address and 32-bit data. Writes take effect at the next clock edge. Read data is combinational from the address. Several zero-value rules make the block more than a plain down-counter. Writing zero to load or counter while the prescaler is zero stops the timer without an event. Auto-reload with a zero reload value and zero prescaler fires once and then halts. A zero counter in auto-reload mode is replaced by the reload value.

A cycle that carries an accepted register write does not also advance the counter. The write has priority over a tick in that cycle.

Top module: `prescaled_timer`

## Requirements
- R1: Register offsets: 0x0 load, 0x4 counter, 0x8 control, 0xC status. A read of any other address returns 0, and a write to any other address changes no register.
- R2: Control layout: bit 0 enable, bit 1 auto-reload, bit 2 interrupt enable, bits 15:8 prescaler. All other bits read back as 0.
- R3: One-shot: when the timer is started with count L and prescaler P at a write edge, the status flag (status bit 0) reads 1 exactly L*(P+1) cycles later and not one cycle earlier. The counter then holds 0.
- R4: Auto-reload: at each expiry the counter takes the load value, keeps running, and fires again every L*(P+1) cycles.
- R5: irq is 1 exactly when the status flag is 1 and control bit 2 is 1.
- R6: A status write clears the flag only when data bit 0 is 1, and irq is low on the cycle after the write. A write with bit 0 = 0 leaves the flag unchanged.
- R7: A write to load also sets the counter to that value. When the timer is enabled with prescaler 0, a load write of 0 stops it and does not set the flag.
- R8: When the timer is enabled with prescaler 0, a counter write of 0 stops it without an event, in one-shot mode or in auto-reload mode with load 0.
- R9: When the timer is enabled, in auto-reload mode, with prescaler 0, a counter write of 0 loads the load value instead, and the timer keeps running.
- R10: Auto-reload with load 0 and prescaler 0 fires once and then stays stopped with counter 0.
- R11: Clearing enable, or changing bits 1:0 of control, stops the timer. A stopped counter holds its value.
- R12: A control write with enable and auto-reload set while the counter is 0 reloads the counter from load before counting resumes.
- R13: After reset, load, counter, control and status read 0 and irq is 0.
- R14: Auto-reload with load 0 and a nonzero prescaler P fires again every P+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (4) | Byte address of the register |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data for busAddr (combinational) |
| irq | output | 1 | Interrupt: status flag and interrupt enable |

## Verification
The bench sweeps prescaler and load values in both modes and samples the flag one cycle before and exactly at the computed expiry. A prescaler that is off by one, or that starts from the wrong phase, moves the event by a cycle and fails those checks. Each zero rule is driven on its own. A design that ignores the silent stop would raise the flag on the next tick. A design that skips the zero-load halt would fire again every cycle after the first event. A missing counter substitution would read back 0 and never fire. The bench also freezes the timer mid-count, probes unmapped addresses, and toggles the interrupt enable over a pending flag.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int OFS_LOAD  = 'h0;
  localparam int OFS_COUNT = 'h4;
  localparam int OFS_CTRL  = 'h8;
  localparam int OFS_STAT  = 'hC;

  localparam int EN_BIT  = 0;
  localparam int PER_BIT = 1;
  localparam int IE_BIT  = 2;
  localparam int PRE_LSB = 8;

  typedef struct packed {
    logic ldLoad;     // capture write data into load register
    logic ldCount;    // overwrite counter
    logic fromLoad;   // counter source: load register instead of bus
    logic freeze;     // write cycle: suppress the tick
    logic preRestart; // prescaler field changed
  } strobe_t;
endpackage

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              running,
  input  logic              periodic,
  input  logic [PRE_W-1:0]  prescale,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] loadVal,
  output logic              countZero,
  output logic              loadZero,
  output logic              tick,
  output logic              expire
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] newPre;

  assign newPre    = busWdata[PRE_LSB +: PRE_W];
  assign countZero = (countVal == '0);
  assign loadZero  = (loadVal == '0);
  assign tick      = running && (preCnt == '0) && !st.freeze;
  assign expire    = tick && (countVal[DATA_W-1:1] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (st.preRestart) begin
      preCnt <= newPre;
    end else if (!running || preCnt == '0) begin
      preCnt <= prescale;
    end else begin
      preCnt <= preCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadVal <= '0;
    end else if (st.ldLoad) begin
      loadVal <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (st.ldCount) begin
      countVal <= st.fromLoad ? loadVal : busWdata;
    end else if (expire) begin
      countVal <= periodic ? loadVal : '0;
    end else if (tick) begin
      countVal <= countVal - 1'b1;
    end
  end
endmodule

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              countZero,
  input  logic              loadZero,
  input  logic              expire,
  output strobe_t           st,
  output logic              enable,
  output logic              periodic,
  output logic              irqEn,
  output logic [PRE_W-1:0]  prescale,
  output logic              running,
  output logic              flag,
  output logic              irq
);
  logic wrEn, selLoad, selCount, selCtrl, selStat;
  logic newEn, newPer, presc0, wdZero, cntReplace, ctrlReload, modeChg;
  logic [PRE_W-1:0] newPre;

  assign wrEn     = busValid && busWrite;
  assign selLoad  = wrEn && (busAddr == ADDR_W'(OFS_LOAD));
  assign selCount = wrEn && (busAddr == ADDR_W'(OFS_COUNT));
  assign selCtrl  = wrEn && (busAddr == ADDR_W'(OFS_CTRL));
  assign selStat  = wrEn && (busAddr == ADDR_W'(OFS_STAT));

  assign newEn   = busWdata[EN_BIT];
  assign newPer  = busWdata[PER_BIT];
  assign newPre  = busWdata[PRE_LSB +: PRE_W];
  assign presc0  = (prescale == '0);
  assign wdZero  = (busWdata == '0);
  assign modeChg = ({newPer, newEn} != {periodic, enable});

  assign cntReplace = enable && periodic && presc0 && wdZero;
  assign ctrlReload = newEn && newPer && countZero;

  always_comb begin
    st.ldLoad     = selLoad;
    st.ldCount    = selLoad || selCount || (selCtrl && ctrlReload);
    st.fromLoad   = (selCount && cntReplace) || (selCtrl && ctrlReload);
    st.freeze     = wrEn;
    st.preRestart = selCtrl && (newPre != prescale);
  end

  assign irq = flag && irqEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      periodic <= 1'b0;
      irqEn    <= 1'b0;
      prescale <= '0;
      running  <= 1'b0;
      flag     <= 1'b0;
    end else if (selLoad) begin
      if (enable && presc0 && wdZero) running <= 1'b0;
      else if (enable) running <= 1'b1;
    end else if (selCount) begin
      if (enable && presc0 && wdZero && (!periodic || loadZero))
        running <= 1'b0;
      else if (enable && (!presc0 || (cntReplace ? !loadZero : !wdZero)))
        running <= 1'b1;
    end else if (selCtrl) begin
      enable   <= newEn;
      periodic <= newPer;
      irqEn    <= busWdata[IE_BIT];
      prescale <= newPre;
      if (newEn && ((newPre != '0) || (ctrlReload ? !loadZero : !countZero)))
        running <= 1'b1;
      else if (modeChg)
        running <= 1'b0;
    end else if (selStat) begin
      flag <= flag && !busWdata[0];
    end else if (expire) begin
      flag <= 1'b1;
      if (!periodic || (loadZero && presc0)) running <= 1'b0;
    end
  end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  strobe_t           st;
  logic              enable, periodic, irqEn, running, flag;
  logic [PRE_W-1:0]  prescale;
  logic [DATA_W-1:0] countVal, loadVal, ctrlWord;
  logic              countZero, loadZero, tick, expire;

  ptmr_ctrl #(.DATA_W(DATA_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .countZero(countZero),
    .loadZero(loadZero), .expire(expire), .st(st), .enable(enable),
    .periodic(periodic), .irqEn(irqEn), .prescale(prescale),
    .running(running), .flag(flag), .irq(irq)
  );

  ptmr_datapath #(.DATA_W(DATA_W), .PRE_W(PRE_W)) uData (
    .clk(clk), .rstN(rstN), .st(st), .busWdata(busWdata),
    .running(running), .periodic(periodic), .prescale(prescale),
    .countVal(countVal), .loadVal(loadVal), .countZero(countZero),
    .loadZero(loadZero), .tick(tick), .expire(expire)
  );

  always_comb begin
    ctrlWord = '0;
    ctrlWord[EN_BIT]  = enable;
    ctrlWord[PER_BIT] = periodic;
    ctrlWord[IE_BIT]  = irqEn;
    ctrlWord[PRE_LSB +: PRE_W] = prescale;
  end

  always_comb begin
    if (busAddr == ADDR_W'(OFS_LOAD))       busRdata = loadVal;
    else if (busAddr == ADDR_W'(OFS_COUNT)) busRdata = countVal;
    else if (busAddr == ADDR_W'(OFS_CTRL))  busRdata = ctrlWord;
    else if (busAddr == ADDR_W'(OFS_STAT))  busRdata = DATA_W'(flag);
    else                                    busRdata = '0;
  end
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
  parameter int DATA_W = 32,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              irq,
  input logic              running,
  input logic              enable,
  input logic              periodic,
  input logic              flag,
  input logic              tick,
  input logic              expire,
  input logic              loadZero,
  input logic [PRE_W-1:0]  prescale,
  input logic [DATA_W-1:0] countVal
);
  // R11
  stopped_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !(busValid && busWrite)) |=> $stable(countVal));

  // R3
  flag_needs_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(expire));

  // R11
  tick_only_running_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> (running && enable));

  // R10
  zero_load_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expire && periodic && loadZero && prescale == '0) |=> !running);

  // R6
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == ADDR_W'('hC) && busWdata[0]) |=> !irq);

  // R7
  load_zero_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == ADDR_W'('h0) && busWdata == '0 &&
     enable && prescale == '0) |=> (!running && $stable(flag)));
endmodule

bind prescaled_timer ptmr_checker #(.DATA_W(DATA_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .irq(irq), .running(running),
  .enable(enable), .periodic(periodic), .flag(flag), .tick(tick),
  .expire(expire), .loadZero(loadZero), .prescale(prescale), .countVal(countVal)
);

// File: tb/tb_prescaled_timer.sv
`timescale 1ns/1ps
module tb_prescaled_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  int tests = 0, failed = 0;
  bit done = 0;

  prescaled_timer dut (.clk(clk), .rstN(rstN), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    busAddr = a; #1; v = busRdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(4'h8, 32'h0);
    wr(4'hC, 32'h1);
  endtask

  initial begin
    logic [31:0] v;
    waitc(3);
    rstN = 1'b1;
    waitc(1);
    // R13 reset state
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), v); chk("R13 reset reg", v, 32'h0);
    end
    chk("R13 reset irq", {31'b0, irq}, 32'h0);

    // R2 control layout
    wr(4'h8, 32'hFFFF_FFF8); rd(4'h8, v); chk("R2 ctrl unused bits", v, 32'h0000_FF00);
    wr(4'h8, 32'h0000_AB06); rd(4'h8, v); chk("R2 ctrl fields", v, 32'h0000_AB06);
    wr(4'h8, 32'h0);

    // R7 load write sets counter
    wr(4'h0, 32'h1234); rd(4'h4, v); chk("R7 load sets counter", v, 32'h1234);

    // R3 / R4 sweep: prescaler x load x mode
    for (int pi = 0; pi < 3; pi++) begin
      for (int li = 0; li < 3; li++) begin
        for (int md = 0; md < 2; md++) begin
          int p, l, m;
          p = (pi == 0) ? 0 : (pi == 1) ? 1 : 3;
          l = (li == 0) ? 1 : (li == 1) ? 2 : 5;
          m = l * (p + 1);
          quiesce();
          wr(4'h8, (32'(p) << 8) | 32'h4);
          wr(4'h0, 32'(l));
          wr(4'h8, (32'(p) << 8) | 32'h5 | (32'(md) << 1));
          waitc(m - 1);
          rd(4'hC, v); chk(md ? "R4 no early event" : "R3 no early event", v, 32'h0);
          rd(4'h4, v); chk(md ? "R4 count before expiry" : "R3 count before expiry", v, 32'h1);
          waitc(1);
          rd(4'hC, v); chk(md ? "R4 event on time" : "R3 event on time", v, 32'h1);
          chk("R5 irq with enable", {31'b0, irq}, 32'h1);
          rd(4'h4, v); chk(md ? "R4 reload value" : "R3 count at zero", v, md ? 32'(l) : 32'h0);
          if (md == 1) begin
            waitc(m - 1);
            rd(4'h4, v); chk("R4 second period count", v, 32'h1);
            waitc(1);
            rd(4'h4, v); chk("R4 second reload", v, 32'(l));
          end else begin
            waitc(3);
            rd(4'h4, v); chk("R3 stays stopped", v, 32'h0);
          end
          wr(4'hC, 32'h1);
          if (md == 0) chk("R6 clear drops irq", {31'b0, irq}, 32'h0);
        end
      end
    end

    // R7 load 0 stops silently
    quiesce();
    wr(4'h0, 32'd10); wr(4'h8, 32'h5); waitc(2);
    wr(4'h0, 32'h0); waitc(10);
    rd(4'hC, v); chk("R7 load zero no event", v, 32'h0);
    rd(4'h4, v); chk("R7 load zero counter", v, 32'h0);

    // R8 one-shot counter 0 stops silently
    wr(4'h0, 32'd10); waitc(2);
    wr(4'h4, 32'h0); waitc(10);
    rd(4'hC, v); chk("R8 counter zero no event", v, 32'h0);

    // R9 periodic counter 0 substituted by load
    quiesce();
    wr(4'h0, 32'd5); wr(4'h8, 32'h7); waitc(2);
    wr(4'h4, 32'h0);
    rd(4'h4, v); chk("R9 counter takes load", v, 32'd5);
    waitc(4); rd(4'hC, v); chk("R9 keeps running early", v, 32'h0);
    waitc(1); rd(4'hC, v); chk("R9 keeps running event", v, 32'h1);

    // R12 control write reloads zero counter
    quiesce();
    wr(4'h0, 32'd4); wr(4'h8, 32'h5); waitc(4);
    rd(4'h4, v); chk("R12 one-shot done", v, 32'h0);
    wr(4'hC, 32'h1);
    wr(4'h8, 32'h7);
    rd(4'h4, v); chk("R12 reloaded", v, 32'd4);
    waitc(3); rd(4'hC, v); chk("R12 no early event", v, 32'h0);
    waitc(1); rd(4'hC, v); chk("R12 event", v, 32'h1);

    // R10 periodic load 0 prescaler 0 fires once
    quiesce();
    wr(4'h0, 32'h0); wr(4'h4, 32'd3); wr(4'h8, 32'h7);
    waitc(2); rd(4'hC, v); chk("R10 no early event", v, 32'h0);
    waitc(1); rd(4'hC, v); chk("R10 fires once", v, 32'h1);
    wr(4'hC, 32'h1); waitc(10);
    rd(4'hC, v); chk("R10 no refire", v, 32'h0);
    rd(4'h4, v); chk("R10 counter zero", v, 32'h0);

    // R14 periodic load 0 prescaler 2 refires
    quiesce();
    wr(4'h0, 32'h0); wr(4'h8, 32'h0000_0207);
    waitc(2); rd(4'hC, v); chk("R14 no early event", v, 32'h0);
    waitc(1); rd(4'hC, v); chk("R14 event", v, 32'h1);
    wr(4'hC, 32'h1); waitc(10);
    rd(4'hC, v); chk("R14 refires", v, 32'h1);

    // R11 disabling freezes counter
    quiesce();
    wr(4'h0, 32'd20); wr(4'h8, 32'h1); waitc(3);
    rd(4'h4, v); chk("R11 counting", v, 32'd17);
    wr(4'h8, 32'h0); waitc(5);
    rd(4'h4, v); chk("R11 frozen", v, 32'd17);

    // R5 interrupt enable gating, R6 partial clear
    quiesce();
    wr(4'h0, 32'd2); wr(4'h8, 32'h1); waitc(2);
    rd(4'hC, v); chk("R5 flag set", v, 32'h1);
    chk("R5 irq masked", {31'b0, irq}, 32'h0);
    wr(4'h8, 32'h5);
    chk("R5 irq unmasked", {31'b0, irq}, 32'h1);
    wr(4'hC, 32'h2);
    rd(4'hC, v); chk("R6 bit0 zero keeps flag", v, 32'h1);
    chk("R6 irq kept", {31'b0, irq}, 32'h1);
    wr(4'hC, 32'h1);
    rd(4'hC, v); chk("R6 clear", v, 32'h0);

    // R1 unmapped addresses
    wr(4'h6, 32'h55);
    rd(4'h0, v); chk("R1 unmapped write ignored", v, 32'd2);
    foreach (busAddr[i]) begin end
    for (int a = 1; a < 16; a++) begin
      if ((a % 4) != 0) begin
        rd(4'(a), v); chk("R1 unmapped read", v, 32'h0);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule